// File: doc/BRIEF.md
# Shared Multi-Line Receive Silo with Alarm Threshold

This block collects received characters from eight serial lines into one shared queue of 64 entries. Each line offers a finished character, its framing-error flag and its parity-error flag on a simple push interface. A one-deep holding slot per line keeps the character until a fixed-priority arbiter moves it into the queue, one character per cycle, lowest line first. Each stored entry keeps the character, the number of the line it came from, both error flags and an overrun flag. The overrun flag marks that a character was lost before this one.

The host pops the oldest entry with a one-cycle read strobe. The registered read word has a valid bit, so a service routine can keep reading until the valid bit comes back clear. The receive interrupt has two modes. It can follow "queue not empty", or, with the alarm mode set, it can wait until sixteen characters are queued. This lets a busy host take one interrupt for a batch of characters. A receive-interrupt enable gates the interrupt. A scan enable turns the whole receive path on or off.

Top module: `mux_rx_silo`

## Requirements
- R1: After reset, `rx_irq` is 0 and `rd_word` is 16'h0000.
- R2: A successful pop returns the read word in this layout: bit 15 = valid (1), bit 14 = overrun, bit 13 = framing error, bit 12 = parity error, bits 11:8 = source line number, bits 7:0 = character. Entries come out in the order they were stored.
- R3: The queue holds 64 entries. A character that reaches a full queue is thrown away. The stored entries are not changed.
- R4: After a character is lost, the next entry accepted into the queue has bit 14 set. Later entries have bit 14 clear.
- R5: A pop from an empty queue returns 16'h0000, so the valid bit is clear. It does not disturb any entry stored afterwards.
- R6: When several lines push in the same cycle, their characters are stored one per cycle, in rising line order.
- R7: With alarm mode off, `rx_irq` rises two clock edges after a push into an empty queue. It falls after the pop that empties the queue.
- R8: With alarm mode on, `rx_irq` is high only while 16 or more entries are queued. A pop that leaves 15 entries brings it low.
- R9: With `rx_int_en` low, `rx_irq` stays 0 whatever the queue holds.
- R10: With `scan_en` low, `rx_irq` is 0 and pushes are ignored. Nothing is stored.
- R11: The character and the error flags are stored unchanged, so a break (NUL with framing error) reads back as 16'hA000 + line << 8.
- R12: A push on a line whose earlier character still waits in its holding slot is lost. It counts as a lost character under R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_en | input | 1 | Master enable of the receive path |
| rx_int_en | input | 1 | Receive interrupt enable |
| alarm_en | input | 1 | Interrupt waits for 16 queued entries |
| push_valid | input | LINES | Per-line character ready strobe |
| push_char | input | LINES*8 | Per-line character, line i at bits 8i+7:8i |
| push_ferr | input | LINES | Per-line framing-error flag |
| push_perr | input | LINES | Per-line parity-error flag |
| rd_en | input | 1 | Host pop strobe |
| rd_word | output | 16 | Registered word from the last pop |
| rx_irq | output | 1 | Receive interrupt |

## Verification
A push is caught in its holding slot at the first edge. It reaches the queue at the second edge, assuming no lower line is waiting, so `rx_irq` and the queue level change just after that edge. The bench checks the interrupt at the falling edge one cycle after the push and again one cycle later, and so sees both the "not yet" and the "now" value. `rd_word` is updated at the edge that samples `rd_en`. The scoreboard monitor notes each sampled pop and compares the word at the next falling edge. The enable inputs act combinationally on `rx_irq`, so those checks are taken a time step after the input changes, well before the next edge.

// File: rtl/rxs_pkg.sv
// Shared types and field widths for the multi-line receive silo.
// Assumes at most 16 lines, so a line number fits the 4-bit field.
package rxs_pkg;
    localparam int CHAR_W  = 8;
    localparam int LNUM_W  = 4;
    localparam int WORD_W  = 16;

    // One character as offered by a line, tagged with its source
    typedef struct packed {
        logic              ferr;
        logic              perr;
        logic [LNUM_W-1:0] line;
        logic [CHAR_W-1:0] ch;
    } rx_char_t;

    // One queue entry: loss marker plus the tagged character
    typedef struct packed {
        logic     ovr;
        rx_char_t body;
    } silo_entry_t;
endpackage

// File: rtl/rxs_line_arb.sv
// Per-line holding slots and a fixed-priority arbiter (lowest line wins).
// Each slot holds one character until it is granted. A push to an
// occupied, ungranted slot is lost and reported on `lost`.
// Assumes LINES <= 2**LNUM_W.
module rxs_line_arb
    import rxs_pkg::*;
#(
    parameter int LINES = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scan_en,
    input  logic [LINES-1:0]         push_valid,
    input  logic [LINES*CHAR_W-1:0]  push_char,
    input  logic [LINES-1:0]         push_ferr,
    input  logic [LINES-1:0]         push_perr,
    output logic                     wr_v,
    output rx_char_t                 wr_char,
    output logic                     lost
);
    logic [LINES-1:0]             hold_v;
    logic [LINES-1:0][CHAR_W-1:0] hold_ch;
    logic [LINES-1:0]             hold_fe;
    logic [LINES-1:0]             hold_pe;
    logic [LINES-1:0]             grant;
    logic [LINES-1:0]             take;

    // Pick the lowest-numbered occupied slot
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int i = 0; i < LINES; i++) begin
            if (hold_v[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

    // A push is taken when the slot is free or empties in this cycle
    assign take = push_valid & {LINES{scan_en}} & (~hold_v | grant);

    // A push into an occupied slot that is not leaving is lost
    assign lost = |(push_valid & {LINES{scan_en}} & hold_v & ~grant);

    // Mux the granted slot onto the write port
    always_comb begin
        wr_v    = |grant;
        wr_char = '0;
        for (int i = 0; i < LINES; i++) begin
            if (grant[i]) begin
                wr_char.ferr = hold_fe[i];
                wr_char.perr = hold_pe[i];
                wr_char.line = LNUM_W'(i);
                wr_char.ch   = hold_ch[i];
            end
        end
    end

    // Slot state: load on take, empty on grant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v  <= '0;
            hold_ch <= '0;
            hold_fe <= '0;
            hold_pe <= '0;
        end else begin
            for (int i = 0; i < LINES; i++) begin
                if (take[i]) begin
                    hold_v[i]  <= 1'b1;
                    hold_ch[i] <= push_char[i*CHAR_W +: CHAR_W];
                    hold_fe[i] <= push_ferr[i];
                    hold_pe[i] <= push_perr[i];
                end else if (grant[i]) begin
                    hold_v[i]  <= 1'b0;
                end
            end
        end
    end

    // R6: at most one line granted per cycle
    a_r6_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R6: an occupied slot that was not granted is still occupied next cycle
    a_r6_waiting_kept: assert property (@(posedge clk) disable iff (!rst_n)
        ((hold_v & ~grant) != '0) |=> ((($past(hold_v) & ~$past(grant)) & ~hold_v) == '0));
endmodule

// File: rtl/rxs_silo.sv
// Circular queue of tagged characters with a registered pop word.
// A write that meets a full queue is dropped. Every loss (dropped write
// or the `lost_in` report) marks the next accepted entry with ovr.
// Assumes DEPTH is a power of two.
module rxs_silo
    import rxs_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_v,
    input  rx_char_t          wr_char,
    input  logic              lost_in,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_word,
    output logic [CNT_W-1:0]  count
);
    localparam int PTR_W = $clog2(DEPTH);

    silo_entry_t       mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              lost_q;
    logic              full;
    logic              empty;
    logic              wr_ok;
    logic              rd_ok;

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);
    assign wr_ok = wr_v && !full;
    assign rd_ok = rd_en && !empty;

    // Storage write, no reset needed
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wr_ptr] <= '{ovr: lost_q, body: wr_char};
        end
    end

    // Pointers, level, loss marker and pop word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            lost_q  <= 1'b0;
            rd_word <= '0;
        end else begin
            if (wr_ok) wr_ptr <= wr_ptr + 1'b1;
            if (rd_ok) rd_ptr <= rd_ptr + 1'b1;
            count  <= count + CNT_W'(wr_ok) - CNT_W'(rd_ok);
            lost_q <= (lost_q && !wr_ok) || lost_in || (wr_v && full);
            if (rd_en) begin
                rd_word <= rd_ok ? {1'b1, mem[rd_ptr]} : '0;
            end
        end
    end

    // R3: level never passes the capacity
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R3: level moves by at most one per cycle
    a_r3_level_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count == $past(count) || count == $past(count) + 1'b1
                  || count == $past(count) - 1'b1));

    // R4: a write into a full queue leaves a pending loss marker
    a_r4_drop_marked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_v && full) |=> lost_q);

    // R5: a pop of an empty queue gives an all-zero word
    a_r5_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty) |=> (rd_word == '0));
endmodule

// File: rtl/mux_rx_silo.sv
// Top of the shared receive silo: line arbiter, queue and interrupt level.
// The interrupt follows either "not empty" or "at least ALARM entries".
// It is gated by the receive-interrupt enable and the scan enable.
module mux_rx_silo
    import rxs_pkg::*;
#(
    parameter int LINES = 8,
    parameter int DEPTH = 64,
    parameter int ALARM = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scan_en,
    input  logic                    rx_int_en,
    input  logic                    alarm_en,
    input  logic [LINES-1:0]        push_valid,
    input  logic [LINES*CHAR_W-1:0] push_char,
    input  logic [LINES-1:0]        push_ferr,
    input  logic [LINES-1:0]        push_perr,
    input  logic                    rd_en,
    output logic [WORD_W-1:0]       rd_word,
    output logic                    rx_irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             wr_v;
    rx_char_t         wr_char;
    logic             lost;
    logic [CNT_W-1:0] count;
    logic             level_hit;

    rxs_line_arb #(.LINES(LINES)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .scan_en    (scan_en),
        .push_valid (push_valid),
        .push_char  (push_char),
        .push_ferr  (push_ferr),
        .push_perr  (push_perr),
        .wr_v       (wr_v),
        .wr_char    (wr_char),
        .lost       (lost)
    );

    rxs_silo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_silo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_v    (wr_v),
        .wr_char (wr_char),
        .lost_in (lost),
        .rd_en   (rd_en),
        .rd_word (rd_word),
        .count   (count)
    );

    // Interrupt level for the selected mode
    always_comb begin
        if (alarm_en) level_hit = (count >= CNT_W'(ALARM));
        else          level_hit = (count != '0);
    end

    // Gate the level with both enables
    assign rx_irq = scan_en && rx_int_en && level_hit;

    // R7: an interrupt always has queued data behind it
    a_r7_irq_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |-> (count != '0));

    // R8: in alarm mode the interrupt needs the threshold reached
    a_r8_alarm_level: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_en && rx_irq) |-> (count >= CNT_W'(ALARM)));
endmodule

// File: tb/test_mux_rx_silo.sv
// Scoreboard bench: the driver queues expected words, the monitor checks pops.
module test_mux_rx_silo;
    localparam int CLK_PERIOD = 10;
    localparam int LINES      = 8;
    localparam int CW         = 8;

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic                  scan_en, rx_int_en, alarm_en;
    logic [LINES-1:0]      push_valid;
    logic [LINES*CW-1:0]   push_char;
    logic [LINES-1:0]      push_ferr, push_perr;
    logic                  rd_en;
    logic [15:0]           rd_word;
    logic                  rx_irq;

    int          total = 0;
    int          bad   = 0;
    string       cur_req = "R1";
    logic [15:0] exp_q[$];
    logic        rd_seen = 1'b0;
    logic [15:0] mon_exp;

    always #(CLK_PERIOD/2) clk = ~clk;

    mux_rx_silo i_mux_rx_silo (
        .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .rx_int_en(rx_int_en),
        .alarm_en(alarm_en), .push_valid(push_valid), .push_char(push_char),
        .push_ferr(push_ferr), .push_perr(push_perr), .rd_en(rd_en),
        .rd_word(rd_word), .rx_irq(rx_irq)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mkw(bit ovr, bit fe, bit pe, int line, logic [7:0] ch);
        return {1'b1, ovr, fe, pe, 4'(line), ch};
    endfunction

    // Monitor: note sampled pops, compare the word at the next falling edge
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen) begin
            mon_exp = (exp_q.size() != 0) ? exp_q.pop_front() : 16'h0000;
            check(cur_req, rd_word, mon_exp);
        end
    end

    task automatic push_one(int line, logic [7:0] ch, bit fe, bit pe, bit ovr, bit keep);
        push_valid = '0;
        push_valid[line] = 1'b1;
        push_char[line*CW +: CW] = ch;
        push_ferr[line] = fe;
        push_perr[line] = pe;
        if (keep) exp_q.push_back(mkw(ovr, fe, pe, line, ch));
        @(negedge clk);
        push_valid = '0;
        push_ferr  = '0;
        push_perr  = '0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic drain(int n);
        repeat (n) rd();
        idle(1);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; scan_en = 1'b0; rx_int_en = 1'b0; alarm_en = 1'b0;
        push_valid = '0; push_char = '0; push_ferr = '0; push_perr = '0;
        rd_en = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", {15'b0, rx_irq}, 16'h0);
        check("R1", rd_word, 16'h0000);
        rst_n = 1'b1; scan_en = 1'b1; rx_int_en = 1'b1;
        idle(1);

        // R5: empty pop
        cur_req = "R5";
        rd();
        idle(1);

        // R2 and R7: single push, interrupt timing, format
        cur_req = "R2";
        push_one(5, 8'h41, 1'b0, 1'b1, 1'b0, 1'b1);
        check("R7", {15'b0, rx_irq}, 16'h0);
        idle(1);
        check("R7", {15'b0, rx_irq}, 16'h1);
        rd();
        check("R7", {15'b0, rx_irq}, 16'h0);
        idle(1);

        // R11: break reads back as NUL with framing error
        cur_req = "R11";
        push_one(2, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1);
        idle(2);
        rd();
        idle(1);

        // R6, R12, R4: all lines at once, then line 7 again while it waits
        cur_req = "R6";
        push_valid = '1;
        for (int i = 0; i < LINES; i++) begin
            push_char[i*CW +: CW] = 8'h30 + 8'(i);
            exp_q.push_back(mkw(i == 1, 1'b0, 1'b0, i, 8'h30 + 8'(i)));
        end
        @(negedge clk);
        push_valid = '0;
        push_valid[7] = 1'b1;
        push_char[7*CW +: CW] = 8'h99;
        @(negedge clk);
        push_valid = '0;
        idle(10);
        drain(8);
        cur_req = "R12";
        rd();
        idle(1);

        // R8: alarm threshold
        alarm_en = 1'b1;
        cur_req = "R8";
        for (int k = 0; k < 15; k++) push_one(3, 8'(k), 1'b0, 1'b0, 1'b0, 1'b1);
        idle(3);
        check("R8", {15'b0, rx_irq}, 16'h0);
        push_one(3, 8'h0F, 1'b0, 1'b0, 1'b0, 1'b1);
        idle(1);
        check("R8", {15'b0, rx_irq}, 16'h1);
        rd();
        check("R8", {15'b0, rx_irq}, 16'h0);
        drain(15);
        alarm_en = 1'b0;

        // R9: interrupt enable gating
        cur_req = "R10";
        push_one(1, 8'h55, 1'b0, 1'b0, 1'b0, 1'b1);
        idle(2);
        rx_int_en = 1'b0;
        #1;
        check("R9", {15'b0, rx_irq}, 16'h0);
        rx_int_en = 1'b1;
        #1;
        check("R9", {15'b0, rx_irq}, 16'h1);

        // R10: scan disable drops irq and ignores pushes
        scan_en = 1'b0;
        #1;
        check("R10", {15'b0, rx_irq}, 16'h0);
        push_one(4, 8'h66, 1'b0, 1'b0, 1'b0, 1'b0);
        idle(3);
        scan_en = 1'b1;
        #1;
        check("R10", {15'b0, rx_irq}, 16'h1);
        @(negedge clk);
        rd();
        rd();
        idle(1);

        // R3 and R4: fill, overfill, then one more after a pop
        cur_req = "R3";
        for (int i = 0; i < 64; i++) push_one(i % 8, 8'(i), 1'b0, 1'b0, 1'b0, 1'b1);
        idle(4);
        check("R3", {15'b0, rx_irq}, 16'h1);
        push_one(0, 8'hE0, 1'b0, 1'b0, 1'b0, 1'b0);
        push_one(1, 8'hE1, 1'b0, 1'b0, 1'b0, 1'b0);
        idle(4);
        rd();
        idle(2);
        push_one(6, 8'h5A, 1'b0, 1'b0, 1'b1, 1'b1);
        idle(3);
        drain(63);
        cur_req = "R4";
        rd();
        idle(1);
        cur_req = "R5";
        rd();
        idle(1);
        check("R5", {15'b0, rx_irq}, 16'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule